// File: doc/BRIEF.md
# Fine-Trim Phase Accumulator Oscillator

This block is a numerically controlled oscillator. A wide phase accumulator runs on the free-running system clock and adds a per-cycle increment each cycle. The increment is a fixed nominal value, trimmed up or down by a signed fractional frequency offset. The accumulator's top bit is the generated clock. A carry out of the accumulator gives a once-per-period pulse. Because the trim step is tiny, the output phase can be steered in very small steps: a small frequency change held for a known number of cycles moves the phase by that change times the duration.

A processor loads the 40-bit signed offset one byte lane at a time and then commits it. Committed values are saturated to a band of about ±92 ppm of nominal. A holdover input freezes the trim at the value that was active when holdover began, so later commits stay parked until holdover ends. For large phase corrections, a snap request overwrites the accumulator at once with a supplied coarse phase.

Top module: `trim_dco`

## Requirements
- R1: After reset the phase output, clock output, wrap pulse and snap-done pulse are all zero, and the active offset is zero, so the phase advances by exactly NOMINAL per cycle.
- R2: The offset is a 40-bit two's complement word written in five byte lanes. Lane k (0..4) holds bits 8k+7 down to 8k. Writes to lane numbers 5, 6 and 7 have no effect.
- R3: A commit takes effect only if all five lanes have been written since the last accepted commit. A commit without that has no effect on the increment.
- R4: The accumulator is 48 bits wide and wraps modulo 2^48. Each cycle it adds NOMINAL + ((NOMINAL × offset) >>> 48), computed as a full-width signed product with an arithmetic shift. The new increment applies from the first clock edge after the accepted commit edge.
- R5: A committed offset above +LIMIT becomes +LIMIT, and one below −LIMIT becomes −LIMIT. LIMIT defaults to 25895697857, which is about 92 ppm of 2^48.
- R6: The clock output always equals bit 47 of the phase output.
- R7: The wrap pulse is high for exactly the one cycle after a clock edge at which the addition carried out of bit 47. It stays low after a snap edge.
- R8: A snap request at a clock edge loads the requested phase in place of the increment. The snap-done pulse is high for that one following cycle only.
- R9: On entry to holdover, the offset active at that moment is latched. It drives the increment for as long as holdover is held. Commits made during holdover update the active offset, and it takes over the increment from the first edge after holdover is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | byte-lane write enable |
| wr_lane | input | 3 | byte lane selector |
| wr_byte | input | 8 | byte data for the selected lane |
| commit | input | 1 | apply the staged offset word |
| hold_mode | input | 1 | 1 = holdover, 0 = offset control |
| snap_req | input | 1 | request a coarse phase load |
| snap_phase | input | 48 | phase to load on snap |
| clk_out | output | 1 | generated clock (accumulator MSB) |
| wrap_pulse | output | 1 | one-cycle pulse after each accumulator wrap |
| snap_done | output | 1 | one-cycle pulse after a snap load |
| phase | output | 48 | current accumulator phase |

## Verification
The assertions assume that a commit never arrives in the same cycle as a lane write, and that a snap request lasts one cycle at a time. The bench keeps to both: it writes lanes, commits and snaps on separate cycles, driving each input on the falling edge. The assertions also assume every clamped offset leaves a positive increment, which holds for the default nominal value. Under these conditions the wrap check can use "phase went down". The bench measures each increment as the difference of two phase samples taken one edge apart.

// File: rtl/trim_dco_pkg.sv
package trim_dco_pkg;
    localparam int ACC_W  = 48;
    localparam int OFS_W  = 40;
    localparam int LANE_W = 8;
    localparam int LANES  = OFS_W / LANE_W;

    typedef struct packed {
        logic [OFS_W-1:0] stage;
        logic [LANES-1:0] mask;
        logic [OFS_W-1:0] active;
    } ofs_st_t;

    typedef struct packed {
        logic             hold_prev;
        logic [OFS_W-1:0] hold_ofs;
    } sel_st_t;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             wrap;
        logic             done;
    } acc_st_t;
endpackage

// File: rtl/trim_dco_ofs_reg.sv
module trim_dco_ofs_reg
    import trim_dco_pkg::*;
#(
    parameter logic signed [OFS_W-1:0] LIMIT = 40'sd25895697857
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_lane,
    input  logic [LANE_W-1:0] wr_byte,
    input  logic             commit,
    output logic [OFS_W-1:0] active
);
    localparam logic signed [OFS_W-1:0] NEG_LIMIT = -LIMIT;

    ofs_st_t st_d, st_q;
    logic signed [OFS_W-1:0] staged_s;

    always_comb begin
        st_d     = st_q;
        staged_s = st_q.stage;
        if (wr_en && (int'(wr_lane) < LANES)) begin
            st_d.stage[int'(wr_lane)*LANE_W +: LANE_W] = wr_byte;
            st_d.mask[wr_lane]                         = 1'b1;
        end
        if (commit && (&st_q.mask)) begin
            if (staged_s > LIMIT)           st_d.active = LIMIT;
            else if (staged_s < NEG_LIMIT)  st_d.active = NEG_LIMIT;
            else                            st_d.active = st_q.stage;
            st_d.mask = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

    // R5: the active offset never leaves the clamp band
    a_r5_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(active) <= LIMIT) && ($signed(active) >= NEG_LIMIT));

    // R3: the active offset only moves on a commit
    a_r3_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active));
endmodule

// File: rtl/trim_dco_src_sel.sv
module trim_dco_src_sel
    import trim_dco_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_mode,
    input  logic [OFS_W-1:0] active,
    output logic [OFS_W-1:0] ofs_sel
);
    sel_st_t st_d, st_q;
    logic    entering;

    always_comb begin
        st_d           = st_q;
        entering       = hold_mode && !st_q.hold_prev;
        st_d.hold_prev = hold_mode;
        if (entering) st_d.hold_ofs = active;
        if (!hold_mode)    ofs_sel = active;
        else if (entering) ofs_sel = active;
        else               ofs_sel = st_q.hold_ofs;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: while holdover is held the selected offset is frozen
    a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold_mode |=> (hold_mode -> $stable(ofs_sel)));
endmodule

// File: rtl/trim_dco_acc.sv
module trim_dco_acc
    import trim_dco_pkg::*;
#(
    parameter logic [ACC_W-1:0] NOMINAL = 48'h0800_0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] ofs_sel,
    input  logic             snap_req,
    input  logic [ACC_W-1:0] snap_phase,
    output logic [ACC_W-1:0] acc,
    output logic             wrap,
    output logic             done
);
    localparam int PROD_W = ACC_W + OFS_W + 1;

    acc_st_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic [ACC_W-1:0]         inc;
    logic [ACC_W:0]           sum;

    always_comb begin
        prod   = $signed({1'b0, NOMINAL}) * $signed(ofs_sel);
        scaled = prod >>> ACC_W;
        inc    = NOMINAL + scaled[ACC_W-1:0];
        sum    = {1'b0, st_q.acc} + {1'b0, inc};
        st_d   = st_q;
        if (snap_req) begin
            st_d.acc  = snap_phase;
            st_d.wrap = 1'b0;
            st_d.done = 1'b1;
        end else begin
            st_d.acc  = sum[ACC_W-1:0];
            st_d.wrap = sum[ACC_W];
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc  = st_q.acc;
    assign wrap = st_q.wrap;
    assign done = st_q.done;

    // R8: a snap loads the requested phase and raises done
    a_r8_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (acc == $past(snap_phase)) && done && !wrap);

    // R8: done is a single-cycle pulse for a single-cycle request
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> !done);

    // R7: without a snap, wrap flags exactly a drop in phase
    a_r7_wrap_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> (wrap == (acc < $past(acc))));
endmodule

// File: rtl/trim_dco.sv
module trim_dco
    import trim_dco_pkg::*;
#(
    parameter logic [ACC_W-1:0]        NOMINAL = 48'h0800_0000_0000,
    parameter logic signed [OFS_W-1:0] LIMIT   = 40'sd25895697857
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_lane,
    input  logic [7:0]  wr_byte,
    input  logic        commit,
    input  logic        hold_mode,
    input  logic        snap_req,
    input  logic [47:0] snap_phase,
    output logic        clk_out,
    output logic        wrap_pulse,
    output logic        snap_done,
    output logic [47:0] phase
);
    logic [OFS_W-1:0] ofs_active;
    logic [OFS_W-1:0] ofs_sel;

    trim_dco_ofs_reg #(.LIMIT(LIMIT)) u_ofs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_lane (wr_lane),
        .wr_byte (wr_byte),
        .commit  (commit),
        .active  (ofs_active)
    );

    trim_dco_src_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_mode (hold_mode),
        .active    (ofs_active),
        .ofs_sel   (ofs_sel)
    );

    trim_dco_acc #(.NOMINAL(NOMINAL)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ofs_sel    (ofs_sel),
        .snap_req   (snap_req),
        .snap_phase (snap_phase),
        .acc        (phase),
        .wrap       (wrap_pulse),
        .done       (snap_done)
    );

    assign clk_out = phase[ACC_W-1];

    // R6: generated clock is the phase MSB
    a_r6_clk_msb: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out == phase[47]);
endmodule

// File: tb/trim_dco_tb.sv
module trim_dco_tb;
    localparam logic [47:0]        NOM = 48'h0800_0000_0000;
    localparam logic signed [39:0] LIM = 40'sd25895697857;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_lane = '0;
    logic [7:0]  wr_byte = '0;
    logic        commit = 1'b0;
    logic        hold_mode = 1'b0;
    logic        snap_req = 1'b0;
    logic [47:0] snap_phase = '0;
    logic        clk_out, wrap_pulse, snap_done;
    logic [47:0] phase;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    trim_dco u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lane(wr_lane),
        .wr_byte(wr_byte), .commit(commit), .hold_mode(hold_mode),
        .snap_req(snap_req), .snap_phase(snap_phase), .clk_out(clk_out),
        .wrap_pulse(wrap_pulse), .snap_done(snap_done), .phase(phase)
    );

    function automatic logic [47:0] exp_inc(input logic signed [39:0] o);
        logic signed [39:0] c;
        logic signed [95:0] a, b, p;
        c = o;
        if (o > LIM) c = LIM;
        else if (o < -LIM) c = -LIM;
        a = $signed({48'd0, NOM});
        b = c;
        p = a * b;
        return NOM + p[95:48];
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_lane(input int k, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_lane = 3'(k); wr_byte = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_word(input logic [39:0] w);
        for (int k = 0; k < 5; k++) write_lane(k, w[8*k +: 8]);
    endtask

    task automatic do_commit();
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
    endtask

    // phase step across one edge, sampled on falling edges
    task automatic measure(output logic [47:0] d);
        logic [47:0] p0;
        p0 = phase;
        @(negedge clk);
        d = phase - p0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [47:0] d;
        logic signed [39:0] cur, a_ofs, b_ofs, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 phase", phase, 48'd0);
        check("R1 flags", {45'd0, clk_out, wrap_pulse, snap_done}, 48'd0);
        measure(d);
        check("R1 nominal step", d, NOM);

        // R4 R5 R2 sweep of offsets incl. boundaries
        for (int i = 0; i < 48; i++) begin
            case (i)
                0: v = 40'sd0;
                1: v = 40'sd1;
                2: v = -40'sd1;
                3: v = 40'sd32;
                4: v = -40'sd33;
                5: v = LIM;
                6: v = LIM + 40'sd1;
                7: v = -LIM;
                8: v = -LIM - 40'sd1;
                9: v = 40'sh7F_FFFF_FFFF;
                10: v = 40'sh80_0000_0000;
                default: v = $signed((40'(i) * 40'h13_579B_DF01) >>> (i % 37));
            endcase
            write_word(v);
            do_commit();
            measure(d);
            check("R4/R5 increment", d, exp_inc(v));
        end
        cur = v;

        // R3 partial write then commit is ignored
        write_lane(0, 8'hAA); write_lane(1, 8'h00); write_lane(2, 8'h00); write_lane(3, 8'h00);
        do_commit();
        measure(d);
        check("R3 partial commit ignored", d, exp_inc(cur));
        write_lane(4, 8'hFF);
        do_commit();
        cur = 40'shFF_0000_00AA;
        measure(d);
        check("R3 full commit applies", d, exp_inc(cur));
        // R3 second commit without rewrite ignored
        a_ofs = 40'sd1000000;
        write_lane(0, 8'h55);
        do_commit();
        measure(d);
        check("R3 commit needs all lanes", d, exp_inc(cur));

        // R2 lanes 5..7 ignored
        write_word(a_ofs);
        for (int k = 5; k < 8; k++) write_lane(k, 8'hC3);
        do_commit();
        measure(d);
        check("R2 high lanes ignored", d, exp_inc(a_ofs));
        cur = a_ofs;

        // R9 holdover freezes trim
        b_ofs = -40'sd7000000;
        @(negedge clk); hold_mode = 1'b1;
        measure(d);
        check("R9 hold entry", d, exp_inc(a_ofs));
        write_word(b_ofs);
        do_commit();
        measure(d);
        check("R9 hold ignores commit", d, exp_inc(a_ofs));
        hold_mode = 1'b0;
        measure(d);
        check("R9 release uses new offset", d, exp_inc(b_ofs));
        cur = b_ofs;

        // R6 R7 over many cycles
        for (int c = 0; c < 200; c++) begin
            logic [47:0] p0;
            p0 = phase;
            @(negedge clk);
            check("R6 clk_out msb", {47'd0, clk_out}, {47'd0, phase[47]});
            check("R7 wrap pulse", {47'd0, wrap_pulse}, {47'd0, phase < p0});
        end

        // R8 snap
        @(negedge clk); snap_req = 1'b1; snap_phase = 48'hFFFF_FFFF_FFF0;
        @(negedge clk); snap_req = 1'b0;
        check("R8 snap phase", phase, 48'hFFFF_FFFF_FFF0);
        check("R8 done high", {47'd0, snap_done}, 48'd1);
        check("R7 no wrap on snap", {47'd0, wrap_pulse}, 48'd0);
        @(negedge clk);
        check("R8 done one cycle", {47'd0, snap_done}, 48'd0);
        check("R8 resumes stepping", phase, 48'hFFFF_FFFF_FFF0 + exp_inc(cur));
        check("R7 wrap after snap", {47'd0, wrap_pulse}, 48'd1);

        finish_run();
    end
endmodule